// File: doc/BRIEF.md
# Branch Resolve and Annul Unit

This unit sits beside the register-read (RF) stage of a five-stage pipeline. Each cycle it looks at the decoded class of the instruction in RF, that instruction's PC, its 16-bit branch displacement and its source operand. The operand is taken after bypassing, so it is always the most recent value. From these it decides whether fetch must be redirected and to which address. For every branch or jump it also produces the return address that is written to the destination register.

When the unit redirects fetch, the instruction already fetched behind the branch must not run. The unit raises an annul strobe so that instruction is swapped for a NOP as it moves into RF. One cycle later a registered flag marks the RF occupant as that NOP. While the flag is set, the unit ignores whatever class is presented, so an annulled branch can neither redirect nor write a link.

A build parameter removes annulment. This models a faulty pipeline in which the slot instruction runs and its effects become visible.

Top module: `br_resolve_unit`

## Requirements
- R1: After reset `slot_nop` is 0 and, with class OTHER (2'b00) presented, `redirect`, `annul_if` and `link_we` are 0.
- R2: Class encoding: 2'b01 branch-if-zero, 2'b10 branch-if-nonzero, 2'b11 register jump, 2'b00 other. Branch-if-zero redirects when `rf_opnd` is 0, branch-if-nonzero redirects when it is not 0, and class OTHER never redirects.
- R3: A taken conditional branch sets `redirect_pc` to `rf_pc` + 4 + 4 × sign-extended `rf_disp`.
- R4: A register jump always redirects, to `rf_opnd` with bits [1:0] cleared.
- R5: For classes 2'b01, 2'b10 and 2'b11, `link_we` is 1 and `link_data` is `rf_pc` + 4, whether or not the instruction is taken. For class OTHER, `link_we` is 0.
- R6: When ANNUL_EN is 1, `annul_if` equals `redirect` in the same cycle. A branch that is not taken raises no annul.
- R7: In the cycle after `annul_if` is 1, `slot_nop` is 1. During that cycle the presented class is ignored: `redirect`, `annul_if` and `link_we` are 0.
- R8: When ANNUL_EN is 0, `annul_if` and `slot_nop` stay 0. The instruction after a taken branch then resolves normally and may itself redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_class | input | 2 | Decoded class of the RF-stage instruction |
| rf_pc | input | 32 | PC of the RF-stage instruction |
| rf_disp | input | 16 | Signed word displacement of a branch |
| rf_opnd | input | 32 | Bypassed source operand |
| redirect | output | 1 | Fetch must load `redirect_pc` |
| redirect_pc | output | 32 | Branch or jump target |
| annul_if | output | 1 | Replace the IF-stage instruction with a NOP |
| link_we | output | 1 | Write `link_data` to the destination register |
| link_data | output | 32 | Return address, RF PC + 4 |
| slot_nop | output | 1 | RF occupant is an injected NOP |

## Verification
The hardest case to reach is a branch sitting in the annulled slot, because it only appears right behind a taken branch. The stimulus presents a second taken-looking branch in the cycle directly after a redirect. The annulling build must ignore it, while the fault build, driven with the same inputs, must follow it. Sequences with back-to-back branches, negative displacements and misaligned jump operands exercise the target arithmetic and the timing of the slot flag.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_BRZ   = 2'b01,
    CLS_BRNZ  = 2'b10,
    CLS_JUMP  = 2'b11
  } br_class_e;
endpackage

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_class_e       cls,
  input  logic            live,
  input  logic [XLEN-1:0] opnd,
  output logic            taken,
  output logic            is_ctl
);
  logic zero;

  always_comb begin
    zero   = (opnd == '0);
    taken  = 1'b0;
    is_ctl = 1'b0;
    if (live) begin
      unique case (cls)
        CLS_BRZ:  begin taken = zero;  is_ctl = 1'b1; end
        CLS_BRNZ: begin taken = !zero; is_ctl = 1'b1; end
        CLS_JUMP: begin taken = 1'b1;  is_ctl = 1'b1; end
        default:  begin taken = 1'b0;  is_ctl = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16
) (
  input  br_class_e         cls,
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   opnd,
  output logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   seq_pc
);
  localparam int EXT_W = XLEN - DISP_W - 2;
  logic [XLEN-1:0] offset;

  always_comb begin
    seq_pc = pc + XLEN'(4);
    offset = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    if (cls == CLS_JUMP) target = {opnd[XLEN-1:2], 2'b00};
    else                 target = seq_pc + offset;
  end
endmodule

// File: rtl/br_slot.sv
module br_slot #(
  parameter bit ANNUL_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic redirect,
  output logic annul,
  output logic slot_nop
);
  logic nop_d, nop_q;

  generate
    if (ANNUL_EN) begin : g_annul
      always_comb annul = redirect;
    end else begin : g_fault
      always_comb annul = 1'b0;
    end
  endgenerate

  always_comb nop_d = annul;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nop_q <= 1'b0;
    else        nop_q <= nop_d;
  end

  assign slot_nop = nop_q;

  a_r7_nop_follows_annul: assert property (@(posedge clk) disable iff (!rst_n)
    annul |=> slot_nop);
  a_r7_no_double_annul: assert property (@(posedge clk) disable iff (!rst_n)
    annul |=> !annul);
  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ANNUL_EN |-> (!annul && !slot_nop));
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int DISP_W   = 16,
  parameter bit ANNUL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rf_class,
  input  logic [XLEN-1:0]   rf_pc,
  input  logic [DISP_W-1:0] rf_disp,
  input  logic [XLEN-1:0]   rf_opnd,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              annul_if,
  output logic              link_we,
  output logic [XLEN-1:0]   link_data,
  output logic              slot_nop
);
  br_class_e cls;
  logic      live, taken, is_ctl;

  assign cls  = br_class_e'(rf_class);
  assign live = !slot_nop;

  br_cond #(.XLEN(XLEN)) u_cond (
    .cls(cls), .live(live), .opnd(rf_opnd), .taken(taken), .is_ctl(is_ctl)
  );

  br_target #(.XLEN(XLEN), .DISP_W(DISP_W)) u_tgt (
    .cls(cls), .pc(rf_pc), .disp(rf_disp), .opnd(rf_opnd),
    .target(redirect_pc), .seq_pc(link_data)
  );

  br_slot #(.ANNUL_EN(ANNUL_EN)) u_slot (
    .clk(clk), .rst_n(rst_n), .redirect(taken), .annul(annul_if), .slot_nop(slot_nop)
  );

  assign redirect = taken;
  assign link_we  = is_ctl;

  a_r7_slot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    slot_nop |-> (!redirect && !link_we));
  a_r4_jump_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_JUMP && live) |-> (redirect && redirect_pc[1:0] == 2'b00));
  a_r6_no_annul_without_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    annul_if |-> redirect);
  a_r5_other_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_OTHER) |-> !link_we);
endmodule

// File: tb/sim_br_resolve_unit.sv
module sim_br_resolve_unit;
  localparam int PER = 10;

  typedef struct {
    logic        redir;
    logic [31:0] tgt;
    logic        ann;
    logic        lwe;
    logic [31:0] ldat;
    logic        snop;
    logic        f_redir;
    logic        f_lwe;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rf_class = 2'b00;
  logic [31:0] rf_pc = '0;
  logic [15:0] rf_disp = '0;
  logic [31:0] rf_opnd = '0;
  logic        redirect, annul_if, link_we, slot_nop;
  logic [31:0] redirect_pc, link_data;
  logic        f_redirect, f_annul, f_link_we, f_slot_nop;
  logic [31:0] f_redirect_pc, f_link_data;

  int checks = 0, errors = 0;
  exp_t sb[$];
  logic model_nop = 1'b0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  br_resolve_unit u0 (
    .clk(clk), .rst_n(rst_n), .rf_class(rf_class), .rf_pc(rf_pc), .rf_disp(rf_disp),
    .rf_opnd(rf_opnd), .redirect(redirect), .redirect_pc(redirect_pc), .annul_if(annul_if),
    .link_we(link_we), .link_data(link_data), .slot_nop(slot_nop)
  );

  br_resolve_unit #(.ANNUL_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .rf_class(rf_class), .rf_pc(rf_pc), .rf_disp(rf_disp),
    .rf_opnd(rf_opnd), .redirect(f_redirect), .redirect_pc(f_redirect_pc), .annul_if(f_annul),
    .link_we(f_link_we), .link_data(f_link_data), .slot_nop(f_slot_nop)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [1:0] cls, logic [31:0] pc, logic [15:0] disp,
                      logic [31:0] op, string tag);
    exp_t e;
    logic take, ctl;
    @(negedge clk);
    rf_class = cls; rf_pc = pc; rf_disp = disp; rf_opnd = op;
    ctl  = (cls != 2'b00);
    take = (cls == 2'b01) ? (op == 0) : (cls == 2'b10) ? (op != 0) : (cls == 2'b11);
    e.tag     = tag;
    e.snop    = model_nop;
    e.redir   = take && !model_nop;
    e.lwe     = ctl && !model_nop;
    e.f_redir = take;
    e.f_lwe   = ctl;
    e.ann     = e.redir;
    e.ldat    = pc + 32'd4;
    e.tgt     = (cls == 2'b11) ? (op & ~32'd3)
              : pc + 32'd4 + {{14{disp[15]}}, disp, 2'b00};
    model_nop = e.ann;
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(PER/4);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " redirect"}, 32'(redirect), 32'(e.redir));
        chk({e.tag, " annul"}, 32'(annul_if), 32'(e.ann));
        chk({e.tag, " link_we"}, 32'(link_we), 32'(e.lwe));
        chk({e.tag, " slot_nop"}, 32'(slot_nop), 32'(e.snop));
        if (e.redir) chk({e.tag, " target"}, redirect_pc, e.tgt);
        if (e.lwe) chk({e.tag, " link"}, link_data, e.ldat);
        chk({e.tag, " R8 fault redirect"}, 32'(f_redirect), 32'(e.f_redir));
        chk({e.tag, " R8 fault annul/nop"}, 32'({f_annul, f_slot_nop}), 32'd0);
        if (e.f_redir) chk({e.tag, " R8 fault target"}, f_redirect_pc, e.tgt);
        chk({e.tag, " R8 fault link_we"}, 32'(f_link_we), 32'(e.f_lwe));
      end
    end
  end

  initial begin : watchdog
    #(PER * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #(PER/4);
    chk("R1 slot_nop in reset", 32'(slot_nop), 32'd0);
    chk("R1 redirect in reset", 32'(redirect), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b00, 32'h0, 16'h0, 32'h0, "R1 other after reset");
    step(2'b01, 32'h4, 16'h0001, 32'h0, "R2 R3 R5 R6 brz taken");
    step(2'b01, 32'h8, 16'h0005, 32'h0, "R7 brz in annulled slot");
    step(2'b00, 32'hC, 16'h0, 32'h0, "R7 after slot");
    step(2'b10, 32'h100, 16'hFFFE, 32'h7, "R2 R3 brnz taken negative disp");
    step(2'b10, 32'h104, 16'h0003, 32'h0, "R7 brnz in slot");
    step(2'b10, 32'h200, 16'h0010, 32'h0, "R2 R6 brnz not taken");
    step(2'b01, 32'h204, 16'h0010, 32'h5, "R2 R5 R6 brz not taken");
    step(2'b11, 32'h300, 16'h0, 32'h13, "R4 jump misaligned operand");
    step(2'b11, 32'h304, 16'h0, 32'h40, "R7 jump in slot");
    step(2'b11, 32'h308, 16'h0, 32'hFFFF_FFFF, "R4 jump all ones");
    step(2'b00, 32'h30C, 16'h0, 32'h0, "R7 other in slot");
    step(2'b01, 32'hFFFF_FFF8, 16'h7FFF, 32'h0, "R3 brz wrap");
    step(2'b00, 32'h10, 16'h0, 32'h0, "R1 R5 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule